// File: doc/BRIEF.md
# Edge-Selectable Port Interrupt Controller

This block collects interrupt requests for a small 8-bit controller core. It watches a group of input pins. For each pin it latches a pending flag when that pin shows the edge chosen for it. Each pin can be masked on its own. The block also takes a one-cycle timer wrap strobe as an internal source. That source has no pending flag: it raises the request only in the cycle of the strobe, and only when its enable bit is set.

Software reaches three registers through a simple write port and a read port: the pin mask register, the edge select register and the pending register. A mode input decides what the pin logic does with a pending edge. In one mode it interrupts the core. In the other mode it only signals a wakeup from power-down, and the pins raise no request. The pending register has no reset value, so software clears it before it unmasks any pin.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset, the mask register reads as all ones (every pin masked) and the edge select register reads as all ones (every pin on the falling edge).
- R2: When a pin's edge select bit is 0, a 0-to-1 change on that pin sets its pending bit. The bit becomes visible on the third rising clock edge after the pin changes. A 1-to-0 change on that pin leaves the bit clear.
- R3: When a pin's edge select bit is 1, a 1-to-0 change on that pin sets its pending bit, and a 0-to-1 change leaves it clear.
- R4: A pin's pending bit is set on its selected edge whether or not that pin is masked.
- R5: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: If a selected edge reaches a pending bit in the same cycle as a write that clears that bit, the bit ends up set.
- R7: With mode_i = 1, the pin part of irq_o is the OR over all pins of pending AND NOT mask.
- R8: When every mask bit is 1, the pins raise neither irq_o nor wake_o, whatever the pending register holds.
- R9: With mode_i = 0, the pins never raise irq_o. In both modes, wake_o equals the OR over all pins of pending AND NOT mask.
- R10: irq_o is high in any cycle where tmr_wrap_i and tmr_ie_i are both 1. This source keeps no state, so it stops raising irq_o in the cycle after the strobe.
- R11: Register select codes on wr_sel_i and rd_sel_i are: 0 = mask, 1 = edge select, 2 = pending. A read with code 3 returns zero, and a write with code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | 8 | Read data (combinational) |
| mode_i | input | 1 | 1 = pins interrupt the core, 0 = pins only wake |
| tmr_wrap_i | input | 1 | One-cycle strobe when the timer wraps |
| tmr_ie_i | input | 1 | Timer interrupt enable |
| wake_o | output | 1 | Wakeup status from an unmasked pending pin |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Each pin is swept on its own under both edge selects. The selected edge and the opposite edge are both applied, which separates a swapped edge polarity from a wrong pin index. A sweep over pairs of pending and mask patterns, built arithmetically, checks irq_o and wake_o against the masked OR in both modes. Patterns with every mask bit set show that stale pending bits stay silent. A clear write timed to land with a new edge shows which of the two wins. Timer strobes with the enable on and off separate the direct timer path from the latched pin path.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_EDGE = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
  parameter int NPINS = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] fall_sel_i,
  output logic [NPINS-1:0] hit_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            cur;

    assign cur = sync_q[SYNC-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], pin_i[p]};
        prev_q <= cur;
      end
    end

    // select 1: falling, select 0: rising
    assign hit_o[p] = fall_sel_i[p] ? (prev_q & ~cur) : (cur & ~prev_q);
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [NPINS-1:0] hit_i,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] fall_o,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] mask_q, fall_q, pend_q, pend_keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      fall_q <= '1;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_MASK) mask_q <= wr_data_i;
      if (wr_sel_i == SEL_EDGE) fall_q <= wr_data_i;
    end
  end

  always_comb begin
    pend_keep = pend_q;
    if (wr_en_i && wr_sel_i == SEL_PEND) pend_keep = pend_q & wr_data_i;
  end

  // no reset value: software clears it before unmasking
  always_ff @(posedge clk_i) begin
    if (rst_ni) pend_q <= pend_keep | hit_i;
  end

  assign mask_o = mask_q;
  assign fall_o = fall_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] pend_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             mode_i,
  input  logic             tmr_wrap_i,
  input  logic             tmr_ie_i,
  output logic             wake_o,
  output logic             irq_o
);
  logic pin_req;
  assign pin_req = |(pend_i & ~mask_i);
  assign wake_o  = pin_req;
  assign irq_o   = (pin_req & mode_i) | (tmr_wrap_i & tmr_ie_i);
endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SYNC  = 2,
  localparam int SW   = $bits(reg_sel_e)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [SW-1:0]    wr_sel_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [SW-1:0]    rd_sel_i,
  output logic [NPINS-1:0] rd_data_o,
  input  logic             mode_i,
  input  logic             tmr_wrap_i,
  input  logic             tmr_ie_i,
  output logic             wake_o,
  output logic             irq_o
);
  logic [NPINS-1:0] hit, mask, fall, pend;

  pic_edge_det #(.NPINS(NPINS), .SYNC(SYNC)) u_det (
    .clk_i, .rst_ni, .pin_i, .fall_sel_i(fall), .hit_o(hit)
  );

  pic_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i(reg_sel_e'(wr_sel_i)), .wr_data_i,
    .hit_i(hit), .mask_o(mask), .fall_o(fall), .pend_o(pend)
  );

  pic_req #(.NPINS(NPINS)) u_req (
    .pend_i(pend), .mask_i(mask), .mode_i, .tmr_wrap_i, .tmr_ie_i, .wake_o, .irq_o
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_MASK: rd_data_o = mask;
      SEL_EDGE: rd_data_o = fall;
      SEL_PEND: rd_data_o = pend;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/port_irq_ctrl_chk.sv
module port_irq_ctrl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [NPINS-1:0] wr_data_i,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] fall,
  input logic [NPINS-1:0] pend,
  input logic             mode_i,
  input logic             tmr_wrap_i,
  input logic             tmr_ie_i,
  input logic             wake_o,
  input logic             irq_o
);
  logic pend_wr;
  assign pend_wr = wr_en_i && (wr_sel_i == 2'd2);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_REGS: assert (mask == '1 && fall == '1); // R1
    end
  end

  AST_PEND_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_wr && hit == '0) |=> $stable(pend)); // R2

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit))); // R6

  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_wr && hit == '0) |=> (pend == ($past(pend) & $past(wr_data_i)))); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1 && !(tmr_wrap_i && tmr_ie_i)) |-> (!irq_o && !wake_o)); // R8

  AST_WAKE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !(tmr_wrap_i && tmr_ie_i)) |-> !irq_o); // R9

  AST_TMR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_wrap_i && tmr_ie_i) |-> irq_o); // R10

  AST_PIN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && wake_o) |-> irq_o); // R7
endmodule

bind port_irq_ctrl port_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .hit(hit), .mask(mask), .fall(fall), .pend(pend),
  .mode_i(mode_i), .tmr_wrap_i(tmr_wrap_i), .tmr_ie_i(tmr_ie_i),
  .wake_o(wake_o), .irq_o(irq_o)
);

// File: tb/sim_port_irq_ctrl.sv
module sim_port_irq_ctrl;
  localparam int N = 8;
  localparam logic [1:0] S_MASK = 2'd0, S_EDGE = 2'd1, S_PEND = 2'd2, S_NONE = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b1;
  logic [N-1:0] pin = '0, wr_data = '0, rd_data;
  logic wr_en = 1'b0, mode = 1'b1, tmr_wrap = 1'b0, tmr_ie = 1'b0, wake, irq;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  port_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .mode_i(mode),
    .tmr_wrap_i(tmr_wrap), .tmr_ie_i(tmr_ie), .wake_o(wake), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [N-1:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  // load pending with pattern p using rising edges, then return pins low
  task automatic load_pend(input logic [N-1:0] p);
    wr(S_EDGE, '0);
    pin = '0; cyc(4);
    wr(S_PEND, '0);
    pin = p; cyc(4);
    pin = '0; cyc(4);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    #1 rst_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    rd(S_MASK, r); check("R1 mask reset", r, 8'hFF);
    rd(S_EDGE, r); check("R1 edge reset", r, 8'hFF);
    // stale pending of unknown content stays silent while all masked
    check("R8 irq at reset", irq, 0);
    check("R8 wake at reset", wake, 0);

    // per pin sweep, both edge selects, all pins masked
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < N; p++) begin
        logic [N-1:0] base;
        base = e ? '1 : '0;
        wr(S_EDGE, base);
        pin = base; cyc(4);
        wr(S_PEND, '0);
        pin[p] = ~base[p];
        cyc(2);
        rd(S_PEND, r);
        check(e ? "R3 latency early" : "R2 latency early", r, 0);
        cyc(1);
        rd(S_PEND, r);
        check(e ? "R3 selected edge" : "R2 selected edge", r, 1 << p);
        check("R4 masked irq", irq, 0);
        wr(S_PEND, '0);
        pin[p] = base[p]; cyc(4);
        rd(S_PEND, r);
        check(e ? "R3 opposite edge" : "R2 opposite edge", r, 0);
      end
    end

    // R5: partial clear
    load_pend(8'hA5);
    rd(S_PEND, r); check("R5 loaded", r, 8'hA5);
    wr(S_PEND, 8'h0F);
    rd(S_PEND, r); check("R5 partial clear", r, 8'h05);

    // R11: select 3 reads zero, write changes nothing
    wr(S_NONE, 8'h00);
    rd(S_NONE, r); check("R11 read none", r, 0);
    rd(S_MASK, r); check("R11 mask kept", r, 8'hFF);
    rd(S_EDGE, r); check("R11 edge kept", r, 8'h00);
    rd(S_PEND, r); check("R11 pend kept", r, 8'h05);

    // R6: edge and clear collide on pin 3
    wr(S_PEND, '0);
    pin[3] = 1'b1;
    cyc(2);
    wr_en = 1'b1; wr_sel = S_PEND; wr_data = '0;
    cyc(1);
    wr_en = 1'b0;
    rd(S_PEND, r); check("R6 edge wins", r, 8'h08);
    pin = '0; cyc(4);

    // R7/R8/R9 sweep over pending x mask patterns, both modes
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] pp;
      pp = N'((i * 53 + 7) ^ (i << 3));
      wr(S_MASK, '1);
      load_pend(pp);
      for (int j = 0; j < 12; j++) begin
        logic [N-1:0] mm;
        mm = (j == 0) ? '1 : N'((j * 97 + 11) ^ (i * 29));
        wr(S_MASK, mm);
        mode = 1'b1; #1;
        check(mm == '1 ? "R8 irq masked" : "R7 irq", irq, |(pp & ~mm));
        check("R9 wake mode1", wake, |(pp & ~mm));
        mode = 1'b0; #1;
        check("R9 irq mode0", irq, 0);
        check(mm == '1 ? "R8 wake masked" : "R9 wake mode0", wake, |(pp & ~mm));
        @(negedge clk);
      end
    end

    // R10 timer path, pins masked and pending cleared
    wr(S_MASK, '1);
    wr(S_PEND, '0);
    mode = 1'b1;
    tmr_wrap = 1'b1; tmr_ie = 1'b1; #1;
    check("R10 timer req", irq, 1);
    cyc(1);
    tmr_wrap = 1'b0; #1;
    check("R10 timer no memory", irq, 0);
    tmr_wrap = 1'b1; tmr_ie = 1'b0; #1;
    check("R10 timer disabled", irq, 0);
    cyc(1);
    tmr_wrap = 1'b0;
    mode = 1'b0; tmr_wrap = 1'b1; tmr_ie = 1'b1; #1;
    check("R10 timer in wake mode", irq, 1);
    cyc(1);
    tmr_wrap = 1'b0; tmr_ie = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule